// File: doc/BRIEF.md
# Vectored Interrupt Mask Controller

This unit sits beside a small processor core and decides, at each instruction boundary, which hardwired interrupt request is serviced. It has four request lines. The first is a non-maskable line that needs a sustained level and a fresh rising edge. The second is a maskable line that is latched on a positive edge, so a short pulse is enough. The last two are maskable lines that are sampled by level. All five asynchronous inputs, including a serial-data bit that is only passed through, go through a synchronizer chain before any logic sees them.

The core drives strobes for the following operations: setting the global enable, clearing it, writing the mask word, reading the status word, marking an instruction boundary, and acknowledging a request. At a boundary the unit registers the winning request as a source code and a 16-bit vector address. An acknowledge consumes that request. It clears the global enable when the source is maskable. It clears the edge latch when the latched line wins. It disarms the non-maskable line until that line is released and raised again.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset the global enable is 0, all three masks are 1, the edge latch and the non-maskable arm state are clear, `take_valid` is 0, and a status read returns 0x07 while all inputs are low.
- R2: `ien_set` sets the global enable and `ien_clr` clears it. When both are high in the same cycle the enable ends up 0. Status bit 3 shows the enable.
- R3: A mask write loads the masks from data bits 2..0 only when data bit 3 is 1. Bit 0 masks the low level line, bit 1 the middle level line, and bit 2 the edge line. Otherwise the masks are unchanged.
- R4: A rising edge on the edge line sets a latch, which holds until the edge source is acknowledged or a mask write has data bit 4 set. A new edge arriving in the same cycle as a clear leaves the latch set.
- R5: The two level lines are serviceable only if the synchronized level is still high at the boundary.
- R6: The non-maskable line is serviceable while high and armed, whatever the enable and the masks hold. After it is acknowledged it is not taken again until it goes low and rises again.
- R7: Priority is non-maskable (source 0, vector 0x0024), then edge (source 1, 0x003C), then middle level (source 2, 0x0034), then low level (source 3, 0x002C). A maskable line is serviceable only when the enable is 1 and its mask is 0.
- R8: On a boundary strobe `take_valid`, `take_src` and `take_vec` are loaded one cycle later, and they hold between boundaries. An `ack` clears `take_valid` and takes precedence over a boundary in the same cycle.
- R9: Acknowledging a maskable source clears the global enable. Acknowledging the non-maskable source leaves it unchanged.
- R10: A status read returns masks in bits 2..0, enable in bit 3, low-line level in bit 4, middle-line level in bit 5, edge latch in bit 6 and synchronized serial input in bit 7. The pending bits are shown regardless of the masks.
- R11: An `ack` while `take_valid` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_a | input | 1 | Asynchronous non-maskable request |
| r75_a | input | 1 | Asynchronous edge-latched request |
| r65_a | input | 1 | Asynchronous middle level request |
| r55_a | input | 1 | Asynchronous low level request |
| sin_a | input | 1 | Asynchronous serial data bit for status |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable |
| msk_wr | input | 1 | Mask word write strobe |
| msk_wdata | input | 8 | Mask word |
| stat_rd | input | 1 | Status read strobe |
| stat_rdata | output | 8 | Registered status word |
| boundary | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Acknowledge of the reported request |
| take_valid | output | 1 | A request was selected at the last boundary |
| take_src | output | 2 | Selected source code |
| take_vec | output | 16 | Selected vector address |

## Verification
The delicate coincidence is a latch clear (a mask write with bit 4 set) landing in the same cycle that a synchronized rising edge on the edge line sets the latch. The bench raises the edge input and counts the synchronizer stages and the edge detector to place the write exactly on the setting edge. A status read must then show the latch still set, and a second clear-only write must drop it. A second coincidence is acknowledge plus boundary in one cycle, which must leave `take_valid` low. A sweep over masks, enable, level inputs, an edge pulse and the non-maskable level compares the selected vector and the status word against a priority model written in the bench.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SRC_NMI = 2'd0,
    SRC_R75 = 2'd1,
    SRC_R65 = 2'd2,
    SRC_R55 = 2'd3
  } irq_src_e;

  localparam int N_ASYNC = 5;
  localparam int IX_NMI  = 0;
  localparam int IX_R75  = 1;
  localparam int IX_R65  = 2;
  localparam int IX_R55  = 3;
  localparam int IX_SIN  = 4;

  localparam int MSK_WORD_W = 8;
  localparam int MSK_BIT_EN = 3;
  localparam int MSK_BIT_CLR = 4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_a,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d_a;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_trig.sv
module irq_trig (
  input  logic clk,
  input  logic rst,
  input  logic nmi_lvl,
  input  logic hi_lvl,
  input  logic hi_clr_wr,
  input  logic ack_hi,
  input  logic ack_nmi,
  output logic hi_latch,
  output logic nmi_armed
);
  logic hi_d, nmi_d;
  logic hi_rise, nmi_rise;

  assign hi_rise  = hi_lvl & ~hi_d;
  assign nmi_rise = nmi_lvl & ~nmi_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_d      <= 1'b0;
      nmi_d     <= 1'b0;
      hi_latch  <= 1'b0;
      nmi_armed <= 1'b0;
    end else begin
      hi_d  <= hi_lvl;
      nmi_d <= nmi_lvl;
      if (hi_rise)                     hi_latch <= 1'b1;
      else if (hi_clr_wr || ack_hi)    hi_latch <= 1'b0;
      if (nmi_rise)                    nmi_armed <= 1'b1;
      else if (ack_nmi || !nmi_lvl)    nmi_armed <= 1'b0;
    end
  end

  // R4: stored edge survives until a clear source appears
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
    hi_latch && !hi_clr_wr && !ack_hi |=> hi_latch);
  // R4: a fresh edge always leaves the latch set
  a_r4_edge_wins: assert property (@(posedge clk) disable iff (rst)
    hi_rise |=> hi_latch);
  // R6: no re-arm without a new rising edge
  a_r6_rearm_edge: assert property (@(posedge clk) disable iff (rst)
    !nmi_armed && !nmi_rise |=> !nmi_armed);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_vec_pkg::*;
#(
  parameter int          VEC_W   = 16,
  parameter logic [15:0] VEC_NMI = 16'h0024,
  parameter logic [15:0] VEC_R75 = 16'h003C,
  parameter logic [15:0] VEC_R65 = 16'h0034,
  parameter logic [15:0] VEC_R55 = 16'h002C
) (
  input  logic             nmi_srv,
  input  logic             r75_srv,
  input  logic             r65_srv,
  input  logic             r55_srv,
  output logic             any,
  output irq_src_e         sel,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    any = 1'b1;
    sel = SRC_NMI;
    vec = VEC_W'(VEC_NMI);
    if (nmi_srv) begin
      sel = SRC_NMI; vec = VEC_W'(VEC_NMI);
    end else if (r75_srv) begin
      sel = SRC_R75; vec = VEC_W'(VEC_R75);
    end else if (r65_srv) begin
      sel = SRC_R65; vec = VEC_W'(VEC_R65);
    end else if (r55_srv) begin
      sel = SRC_R55; vec = VEC_W'(VEC_R55);
    end else begin
      any = 1'b0;
    end
  end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] VEC_NMI     = 16'h0024,
  parameter logic [15:0] VEC_R75     = 16'h003C,
  parameter logic [15:0] VEC_R65     = 16'h0034,
  parameter logic [15:0] VEC_R55     = 16'h002C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_a,
  input  logic             r75_a,
  input  logic             r65_a,
  input  logic             r55_a,
  input  logic             sin_a,
  input  logic             ien_set,
  input  logic             ien_clr,
  input  logic             msk_wr,
  input  logic [7:0]       msk_wdata,
  input  logic             stat_rd,
  output logic [7:0]       stat_rdata,
  input  logic             boundary,
  input  logic             ack,
  output logic             take_valid,
  output logic [1:0]       take_src,
  output logic [VEC_W-1:0] take_vec
);
  logic [N_ASYNC-1:0] raw_a, lvl;
  logic [2:0]         mask_q;
  logic               ien_q;
  logic               hi_latch, nmi_armed;
  logic               ack_ok, ack_nmi, ack_hi, ack_mask;
  logic               nmi_srv, r75_srv, r65_srv, r55_srv;
  logic               sel_any;
  irq_src_e           sel_src, take_src_q;
  logic [VEC_W-1:0]   sel_vec;

  assign raw_a[IX_NMI] = nmi_a;
  assign raw_a[IX_R75] = r75_a;
  assign raw_a[IX_R65] = r65_a;
  assign raw_a[IX_R55] = r55_a;
  assign raw_a[IX_SIN] = sin_a;

  irq_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_a(raw_a), .q(lvl)
  );

  assign ack_ok   = ack & take_valid;
  assign ack_nmi  = ack_ok & (take_src_q == SRC_NMI);
  assign ack_hi   = ack_ok & (take_src_q == SRC_R75);
  assign ack_mask = ack_ok & (take_src_q != SRC_NMI);

  irq_trig trig_i (
    .clk(clk), .rst(rst),
    .nmi_lvl(lvl[IX_NMI]), .hi_lvl(lvl[IX_R75]),
    .hi_clr_wr(msk_wr & msk_wdata[MSK_BIT_CLR]),
    .ack_hi(ack_hi), .ack_nmi(ack_nmi),
    .hi_latch(hi_latch), .nmi_armed(nmi_armed)
  );

  assign nmi_srv = lvl[IX_NMI] & nmi_armed;
  assign r75_srv = ien_q & hi_latch     & ~mask_q[2];
  assign r65_srv = ien_q & lvl[IX_R65]  & ~mask_q[1];
  assign r55_srv = ien_q & lvl[IX_R55]  & ~mask_q[0];

  irq_arb #(
    .VEC_W(VEC_W), .VEC_NMI(VEC_NMI), .VEC_R75(VEC_R75),
    .VEC_R65(VEC_R65), .VEC_R55(VEC_R55)
  ) arb_i (
    .nmi_srv(nmi_srv), .r75_srv(r75_srv), .r65_srv(r65_srv), .r55_srv(r55_srv),
    .any(sel_any), .sel(sel_src), .vec(sel_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= 1'b0;
      mask_q     <= 3'b111;
      take_valid <= 1'b0;
      take_src_q <= SRC_NMI;
      take_vec   <= '0;
      stat_rdata <= '0;
    end else begin
      if (ien_clr || ack_mask) ien_q <= 1'b0;
      else if (ien_set)        ien_q <= 1'b1;
      if (msk_wr && msk_wdata[MSK_BIT_EN]) mask_q <= msk_wdata[2:0];
      if (ack) begin
        take_valid <= 1'b0;
      end else if (boundary) begin
        take_valid <= sel_any;
        take_src_q <= sel_src;
        take_vec   <= sel_vec;
      end
      if (stat_rd)
        stat_rdata <= {lvl[IX_SIN], hi_latch, lvl[IX_R65], lvl[IX_R55], ien_q, mask_q};
    end
  end

  assign take_src = take_src_q;

  // R9: a maskable acknowledge drops the global enable
  a_r9_ack_clears_ien: assert property (@(posedge clk) disable iff (rst)
    ack && take_valid && take_src_q != SRC_NMI |=> !ien_q);
  // R8: acknowledge consumes the report, even against a boundary
  a_r8_ack_wins: assert property (@(posedge clk) disable iff (rst)
    ack |=> !take_valid);
  // R7: armed non-maskable request always wins the boundary
  a_r7_nmi_first: assert property (@(posedge clk) disable iff (rst)
    !ack && boundary && nmi_srv |=> take_valid && take_src_q == SRC_NMI
                                    && take_vec == VEC_W'(VEC_NMI));
  // R3: masks only move on a gated write
  a_r3_mask_gated: assert property (@(posedge clk) disable iff (rst)
    !(msk_wr && msk_wdata[MSK_BIT_EN]) |=> $stable(mask_q));
endmodule

// File: tb/irq_vec_unit_tb_top.sv
`timescale 1ns/1ps
module irq_vec_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_a = 0, r75_a = 0, r65_a = 0, r55_a = 0, sin_a = 0;
  logic ien_set = 0, ien_clr = 0, msk_wr = 0, stat_rd = 0, boundary = 0, ack = 0;
  logic [7:0]  msk_wdata = '0;
  logic [7:0]  stat_rdata;
  logic        take_valid;
  logic [1:0]  take_src;
  logic [15:0] take_vec;
  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] st;

  always #2.5 clk = ~clk;

  irq_vec_unit dut_i (
    .clk(clk), .rst(rst), .nmi_a(nmi_a), .r75_a(r75_a), .r65_a(r65_a),
    .r55_a(r55_a), .sin_a(sin_a), .ien_set(ien_set), .ien_clr(ien_clr),
    .msk_wr(msk_wr), .msk_wdata(msk_wdata), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .boundary(boundary), .ack(ack),
    .take_valid(take_valid), .take_src(take_src), .take_vec(take_vec)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; nmi_a = 0; r75_a = 0; r65_a = 0; r55_a = 0; sin_a = 0;
    ien_set = 0; ien_clr = 0; msk_wr = 0; stat_rd = 0; boundary = 0; ack = 0;
    step(3);
    rst = 0;
    step(1);
  endtask

  task automatic mwrite(logic [7:0] d);
    msk_wr = 1; msk_wdata = d; step(1); msk_wr = 0; msk_wdata = '0;
  endtask

  task automatic rd(output logic [7:0] v);
    stat_rd = 1; step(1); stat_rd = 0; v = stat_rdata;
  endtask

  task automatic pulse_bnd();
    boundary = 1; step(1); boundary = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; step(1); ack = 0;
  endtask

  task automatic en();
    ien_set = 1; step(1); ien_set = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    rd(st);
    chk("R1 status after reset", st, 8'h07);
    chk("R1 take_valid after reset", take_valid, 0);

    // Sweep: masks, enable, level pair, edge pulse, nmi level  (R7, R5, R10, R6)
    for (int idx = 0; idx < 256; idx++) begin
      logic [2:0] m;
      logic e, p, n, ev;
      logic [1:0] lv, es;
      logic [15:0] evec;
      m = idx[2:0]; e = idx[3]; lv = idx[5:4]; p = idx[6]; n = idx[7];
      do_reset();
      mwrite({5'b00001, m});
      if (e) en();
      r65_a = lv[1]; r55_a = lv[0]; nmi_a = n;
      if (p) begin r75_a = 1; step(1); r75_a = 0; end
      step(4);
      ev = 1; es = 0; evec = 16'h0024;
      if (n) begin es = 0; evec = 16'h0024; end
      else if (e && p && !m[2]) begin es = 1; evec = 16'h003C; end
      else if (e && lv[1] && !m[1]) begin es = 2; evec = 16'h0034; end
      else if (e && lv[0] && !m[0]) begin es = 3; evec = 16'h002C; end
      else ev = 0;
      pulse_bnd();
      if (ev) chk($sformatf("R7 sweep %0d take", idx), {take_valid, take_src, take_vec}, {ev, es, evec});
      else    chk($sformatf("R7 sweep %0d idle", idx), take_valid, 0);
      rd(st);
      chk($sformatf("R10 sweep %0d status", idx), st, {1'b0, p, lv[1], lv[0], e, m});
    end

    // R2 enable set/clear, clear wins
    do_reset();
    ien_set = 1; ien_clr = 1; step(1); ien_set = 0; ien_clr = 0;
    rd(st); chk("R2 set+clr gives 0", st[3], 0);
    en(); rd(st); chk("R2 set", st[3], 1);
    ien_clr = 1; step(1); ien_clr = 0; rd(st); chk("R2 clear", st[3], 0);

    // R3 gated mask write
    mwrite(8'h05); rd(st); chk("R3 ungated write ignored", st[2:0], 3'b111);
    mwrite(8'h0A); rd(st); chk("R3 gated write", st[2:0], 3'b010);

    // R4 clear in the same cycle as a new edge: set wins
    do_reset();
    r75_a = 1; step(2);
    mwrite(8'h10);
    rd(st); chk("R4 edge beats clear", st[6], 1);
    chk("R4 masks untouched by clear", st[2:0], 3'b111);
    mwrite(8'h10); rd(st); chk("R4 clear drops latch", st[6], 0);
    step(3); rd(st); chk("R4 held level no relatch", st[6], 0);
    r75_a = 0;

    // R4/R9 acknowledge of the edge source
    do_reset();
    mwrite(8'h08); en();
    r75_a = 1; step(1); r75_a = 0; step(4);
    pulse_bnd();
    chk("R4 edge taken", {take_valid, take_src, take_vec}, {1'b1, 2'd1, 16'h003C});
    pulse_ack();
    rd(st);
    chk("R4 ack clears latch", st[6], 0);
    chk("R9 maskable ack clears enable", st[3], 0);

    // R6 non-maskable retake rules, R9 enable kept
    do_reset();
    en();
    nmi_a = 1; step(4);
    pulse_bnd();
    chk("R6 nmi taken", {take_valid, take_src, take_vec}, {1'b1, 2'd0, 16'h0024});
    pulse_ack();
    rd(st); chk("R9 nmi ack keeps enable", st[3], 1);
    pulse_bnd(); chk("R6 held nmi not retaken", take_valid, 0);
    nmi_a = 0; step(4); nmi_a = 1; step(4);
    pulse_bnd(); chk("R6 nmi retaken after new edge", {take_valid, take_src}, {1'b1, 2'd0});
    nmi_a = 0;

    // R11 stray acknowledge
    do_reset();
    en();
    pulse_ack();
    rd(st); chk("R11 stray ack keeps enable", st[3], 1);
    chk("R11 stray ack take_valid", take_valid, 0);

    // R8 hold and ack priority; R5 level must persist
    do_reset();
    mwrite(8'h08); en();
    r65_a = 1; step(4);
    pulse_bnd();
    chk("R8 level taken", {take_valid, take_src, take_vec}, {1'b1, 2'd2, 16'h0034});
    r65_a = 0; step(4);
    chk("R8 report holds", {take_valid, take_src}, {1'b1, 2'd2});
    ack = 1; boundary = 1; step(1); ack = 0; boundary = 0;
    chk("R8 ack beats boundary", take_valid, 0);
    en();
    r55_a = 1; step(4); r55_a = 0; step(4);
    pulse_bnd(); chk("R5 dropped level not taken", take_valid, 0);

    // R10 serial bit passthrough
    sin_a = 1; step(4); rd(st); chk("R10 serial bit", st[7], 1);
    sin_a = 0; step(4); rd(st); chk("R10 serial low", st[7], 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule